// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block computes the architectural register updates a processor core performs when it enters an exception, an interrupt or a reset, and when it leaves a handler. It samples single-cycle request strobes together with the live program counter, status word, stack register (general register 15) and vector base. One clock later it presents the following results:

- the saved copies of the program counter, status word and stack register;
- the event code registers;
- the rewritten status word;
- the branch target, qualified by a one-cycle branch-valid pulse.

A request that arrives while the status word already has its block bit set does not produce a normal entry. Instead the controller raises a one-cycle nested-entry error and changes no state.

The surrounding core supplies the current register values every cycle. It uses `br_valid` to redirect fetch to `next_pc` and to write `sr_out` back into its status register. The core performs no write to general register 15 on a return.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On an accepted reset, exception or interrupt entry, `spc`, `ssr` and `sgr` take `cur_pc`, `cur_sr` and `cur_r15` from the request cycle.
- R2: On every accepted entry, `sr_out` has the block bit (bit 28), privilege bit (bit 30) and bank bit (bit 29) set to 1. All other bits not named in R3 or R5 are copied from `cur_sr`.
- R3: The FPU-disable bit (bit 15) of `sr_out` is cleared on a reset entry and copied from `cur_sr` on exception and interrupt entries.
- R4: A reset or exception entry writes its 12-bit code into `expevt[11:0]`. An interrupt entry writes its 12-bit code into `intevt[11:0]`. The upper 20 bits of both registers read zero, and the register not written keeps its value.
- R5: On an interrupt entry with `imask_mode` = 1, bits 7:4 of `sr_out` take `int_level`. With `imask_mode` = 0, and on reset and exception entries, bits 7:4 keep `cur_sr[7:4]`.
- R6: A reset entry branches to 0xA0000000 whatever `vbr` holds.
- R7: An exception entry branches to `vbr` plus an offset chosen by `vec_sel`: 0 gives 0x100, 1 gives 0x400, 2 gives 0x600 and 3 gives 0x100. An interrupt entry always branches to `vbr` + 0x600.
- R8: A return strobe sets `next_pc` to `spc` and `sr_out` to `ssr`. It leaves `spc`, `ssr`, `sgr`, `expevt` and `intevt` unchanged, so the saved stack value is never returned.
- R9: When several strobes arrive in one cycle, reset wins over exception, exception over interrupt, and interrupt over return.
- R10: An exception or interrupt request while `cur_sr` bit 28 is 1 pulses `dbl_err` for one cycle, asserts no `br_valid` and changes no saved or event register. A reset request enters normally regardless of bit 28.
- R11: `br_valid` is 1 in the cycle after each accepted entry or return and 0 otherwise. It is never 1 together with `dbl_err`.
- R12: While `rst_n` is low, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low register reset |
| rst_req | input | 1 | Reset entry request strobe |
| exc_req | input | 1 | Exception entry request strobe |
| exc_code | input | 12 | Event code for reset or exception |
| vec_sel | input | 2 | Exception vector offset select |
| int_req | input | 1 | Interrupt entry request strobe |
| int_code | input | 12 | Interrupt event code |
| int_level | input | 4 | Accepted interrupt priority level |
| imask_mode | input | 1 | 1 = load mask field with accepted level on interrupt |
| rte | input | 1 | Return-from-handler strobe |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 32 | Current status word |
| cur_r15 | input | 32 | Current stack register |
| vbr | input | 32 | Vector base |
| spc | output | 32 | Saved program counter |
| ssr | output | 32 | Saved status word |
| sgr | output | 32 | Saved stack register |
| expevt | output | 32 | Exception/reset event code register |
| intevt | output | 32 | Interrupt event code register |
| sr_out | output | 32 | Status word to write back when `br_valid` is 1 |
| next_pc | output | 32 | Branch target when `br_valid` is 1 |
| br_valid | output | 1 | One-cycle branch/update pulse |
| dbl_err | output | 1 | One-cycle nested-entry error pulse |

## Verification
The properties treat the request strobes as sampled afresh on every edge. They compare each registered result against the inputs of the previous cycle, so they assume the core holds no meaning in a strobe beyond the single cycle it is high. They also assume `cur_sr` reflects the status word current when the strobe is sampled. The bench drives every strobe for exactly one cycle and follows it with an idle cycle. It recomputes the status word, vector and saved values from the stimulus, and it sweeps every vector select, every interrupt level in both mask modes, both block-bit states and all strobe combinations.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN   = 32;
    localparam int CODE_W = 12;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_RESET,
        EV_EXC,
        EV_INT,
        EV_RTE,
        EV_DBL
    } ev_kind_t;

    typedef struct packed {
        logic [XLEN-1:0] spc;
        logic [XLEN-1:0] ssr;
        logic [XLEN-1:0] sgr;
        logic [XLEN-1:0] expevt;
        logic [XLEN-1:0] intevt;
        logic [XLEN-1:0] sr_out;
        logic [XLEN-1:0] next_pc;
        logic            br_valid;
        logic            dbl_err;
    } ctl_regs_t;
endpackage

// File: rtl/exc_event_pick.sv
module exc_event_pick
    import exc_pkg::*;
(
    input  logic     rst_req,
    input  logic     exc_req,
    input  logic     int_req,
    input  logic     rte,
    input  logic     blocked,
    output ev_kind_t kind
);
    always_comb begin
        if (rst_req)      kind = EV_RESET;
        else if (exc_req) kind = blocked ? EV_DBL : EV_EXC;
        else if (int_req) kind = blocked ? EV_DBL : EV_INT;
        else if (rte)     kind = EV_RTE;
        else              kind = EV_NONE;
    end
endmodule

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] RST_VEC = 32'hA000_0000,
    parameter logic [XLEN-1:0] VEC_GEN = 32'h0000_0100,
    parameter logic [XLEN-1:0] VEC_TLB = 32'h0000_0400,
    parameter logic [XLEN-1:0] VEC_INT = 32'h0000_0600
) (
    input  ev_kind_t        kind,
    input  logic [1:0]      vec_sel,
    input  logic [XLEN-1:0] vbr,
    input  logic [XLEN-1:0] spc_q,
    output logic [XLEN-1:0] target
);
    logic [XLEN-1:0] exc_off;

    always_comb begin
        case (vec_sel)
            2'd1:    exc_off = VEC_TLB;
            2'd2:    exc_off = VEC_INT;
            default: exc_off = VEC_GEN;
        endcase
    end

    always_comb begin
        case (kind)
            EV_RESET: target = RST_VEC;
            EV_EXC:   target = vbr + exc_off;
            EV_INT:   target = vbr + VEC_INT;
            EV_RTE:   target = spc_q;
            default:  target = '0;
        endcase
    end
endmodule

// File: rtl/exc_sr_update.sv
module exc_sr_update
    import exc_pkg::*;
#(
    parameter int BL_BIT    = 28,
    parameter int MD_BIT    = 30,
    parameter int RB_BIT    = 29,
    parameter int FD_BIT    = 15,
    parameter int IMASK_LSB = 4,
    parameter int IMASK_W   = 4
) (
    input  ev_kind_t           kind,
    input  logic [XLEN-1:0]    cur_sr,
    input  logic [XLEN-1:0]    ssr_q,
    input  logic [IMASK_W-1:0] int_level,
    input  logic               imask_mode,
    output logic [XLEN-1:0]    sr_new
);
    logic [XLEN-1:0] entry_sr;

    always_comb begin
        entry_sr         = cur_sr;
        entry_sr[BL_BIT] = 1'b1;
        entry_sr[MD_BIT] = 1'b1;
        entry_sr[RB_BIT] = 1'b1;
    end

    always_comb begin
        sr_new = cur_sr;
        case (kind)
            EV_RESET: begin
                sr_new         = entry_sr;
                sr_new[FD_BIT] = 1'b0;
            end
            EV_EXC: sr_new = entry_sr;
            EV_INT: begin
                sr_new = entry_sr;
                if (imask_mode)
                    sr_new[IMASK_LSB +: IMASK_W] = int_level;
            end
            EV_RTE:  sr_new = ssr_q;
            default: sr_new = cur_sr;
        endcase
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int              BL_BIT    = 28,
    parameter int              MD_BIT    = 30,
    parameter int              RB_BIT    = 29,
    parameter int              FD_BIT    = 15,
    parameter int              IMASK_LSB = 4,
    parameter int              IMASK_W   = 4,
    parameter logic [XLEN-1:0] RST_VEC   = 32'hA000_0000,
    parameter logic [XLEN-1:0] VEC_GEN   = 32'h0000_0100,
    parameter logic [XLEN-1:0] VEC_TLB   = 32'h0000_0400,
    parameter logic [XLEN-1:0] VEC_INT   = 32'h0000_0600
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rst_req,
    input  logic                exc_req,
    input  logic [CODE_W-1:0]   exc_code,
    input  logic [1:0]          vec_sel,
    input  logic                int_req,
    input  logic [CODE_W-1:0]   int_code,
    input  logic [IMASK_W-1:0]  int_level,
    input  logic                imask_mode,
    input  logic                rte,
    input  logic [XLEN-1:0]     cur_pc,
    input  logic [XLEN-1:0]     cur_sr,
    input  logic [XLEN-1:0]     cur_r15,
    input  logic [XLEN-1:0]     vbr,
    output logic [XLEN-1:0]     spc,
    output logic [XLEN-1:0]     ssr,
    output logic [XLEN-1:0]     sgr,
    output logic [XLEN-1:0]     expevt,
    output logic [XLEN-1:0]     intevt,
    output logic [XLEN-1:0]     sr_out,
    output logic [XLEN-1:0]     next_pc,
    output logic                br_valid,
    output logic                dbl_err
);
    localparam int PAD_W = XLEN - CODE_W;

    ctl_regs_t       r_d, r_q;
    ev_kind_t        kind;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] sr_new;

    exc_event_pick u_pick (
        .rst_req (rst_req),
        .exc_req (exc_req),
        .int_req (int_req),
        .rte     (rte),
        .blocked (cur_sr[BL_BIT]),
        .kind    (kind)
    );

    exc_vec_sel #(
        .RST_VEC (RST_VEC),
        .VEC_GEN (VEC_GEN),
        .VEC_TLB (VEC_TLB),
        .VEC_INT (VEC_INT)
    ) u_vec (
        .kind    (kind),
        .vec_sel (vec_sel),
        .vbr     (vbr),
        .spc_q   (r_q.spc),
        .target  (target)
    );

    exc_sr_update #(
        .BL_BIT    (BL_BIT),
        .MD_BIT    (MD_BIT),
        .RB_BIT    (RB_BIT),
        .FD_BIT    (FD_BIT),
        .IMASK_LSB (IMASK_LSB),
        .IMASK_W   (IMASK_W)
    ) u_sr (
        .kind       (kind),
        .cur_sr     (cur_sr),
        .ssr_q      (r_q.ssr),
        .int_level  (int_level),
        .imask_mode (imask_mode),
        .sr_new     (sr_new)
    );

    always_comb begin
        r_d          = r_q;
        r_d.br_valid = 1'b0;
        r_d.dbl_err  = 1'b0;
        case (kind)
            EV_RESET, EV_EXC, EV_INT: begin
                r_d.spc      = cur_pc;
                r_d.ssr      = cur_sr;
                r_d.sgr      = cur_r15;
                r_d.sr_out   = sr_new;
                r_d.next_pc  = target;
                r_d.br_valid = 1'b1;
                if (kind == EV_INT)
                    r_d.intevt = {{PAD_W{1'b0}}, int_code};
                else
                    r_d.expevt = {{PAD_W{1'b0}}, exc_code};
            end
            EV_RTE: begin
                r_d.sr_out   = sr_new;
                r_d.next_pc  = target;
                r_d.br_valid = 1'b1;
            end
            EV_DBL:  r_d.dbl_err = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign spc      = r_q.spc;
    assign ssr      = r_q.ssr;
    assign sgr      = r_q.sgr;
    assign expevt   = r_q.expevt;
    assign intevt   = r_q.intevt;
    assign sr_out   = r_q.sr_out;
    assign next_pc  = r_q.next_pc;
    assign br_valid = r_q.br_valid;
    assign dbl_err  = r_q.dbl_err;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter int              BL_BIT    = 28,
    parameter int              MD_BIT    = 30,
    parameter int              RB_BIT    = 29,
    parameter int              FD_BIT    = 15,
    parameter int              IMASK_LSB = 4,
    parameter int              IMASK_W   = 4,
    parameter logic [XLEN-1:0] RST_VEC   = 32'hA000_0000,
    parameter logic [XLEN-1:0] VEC_TLB   = 32'h0000_0400,
    parameter logic [XLEN-1:0] VEC_INT   = 32'h0000_0600
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rst_req,
    input logic                exc_req,
    input logic [CODE_W-1:0]   exc_code,
    input logic [1:0]          vec_sel,
    input logic                int_req,
    input logic                imask_mode,
    input logic                rte,
    input logic [XLEN-1:0]     cur_pc,
    input logic [XLEN-1:0]     cur_sr,
    input logic [XLEN-1:0]     cur_r15,
    input logic [XLEN-1:0]     vbr,
    input logic [XLEN-1:0]     spc,
    input logic [XLEN-1:0]     ssr,
    input logic [XLEN-1:0]     sgr,
    input logic [XLEN-1:0]     expevt,
    input logic [XLEN-1:0]     intevt,
    input logic [XLEN-1:0]     sr_out,
    input logic [XLEN-1:0]     next_pc,
    input logic                br_valid,
    input logic                dbl_err
);
    logic bl_in, take_any, take_exc, take_int, take_rte, nested;

    assign bl_in    = cur_sr[BL_BIT];
    assign take_exc = !rst_req && exc_req && !bl_in;
    assign take_int = !rst_req && !exc_req && int_req && !bl_in;
    assign take_any = rst_req || take_exc || take_int;
    assign take_rte = !rst_req && !exc_req && !int_req && rte;
    assign nested   = !rst_req && (exc_req || int_req) && bl_in;

    AST_SAVE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        take_any |=> (spc == $past(cur_pc)) && (ssr == $past(cur_sr)) && (sgr == $past(cur_r15))); // R1

    AST_MODE_BITS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        take_any |=> sr_out[BL_BIT] && sr_out[MD_BIT] && sr_out[RB_BIT]); // R2

    AST_FD_CLEARED_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !sr_out[FD_BIT]); // R3

    AST_FD_KEPT_ON_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |=> sr_out[FD_BIT] == $past(cur_sr[FD_BIT])); // R3

    AST_EXPEVT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || take_exc) |=> (expevt == {{(XLEN-CODE_W){1'b0}}, $past(exc_code)}) && $stable(intevt)); // R4

    AST_IMASK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (take_int && !imask_mode) |=> sr_out[IMASK_LSB +: IMASK_W] == $past(cur_sr[IMASK_LSB +: IMASK_W])); // R5

    AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> next_pc == RST_VEC); // R6

    AST_TLB_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && vec_sel == 2'd1) |=> next_pc == $past(vbr) + VEC_TLB); // R7

    AST_INT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |=> next_pc == $past(vbr) + VEC_INT); // R7

    AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        take_rte |=> (next_pc == $past(spc)) && (sr_out == $past(ssr)) && $stable(sgr) && $stable(spc)); // R8

    AST_NESTED_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        nested |=> dbl_err && !br_valid && $stable(spc) && $stable(expevt) && $stable(intevt)); // R10

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> !dbl_err); // R11

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_any || take_rte) |=> !br_valid); // R11
endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .BL_BIT    (BL_BIT),
    .MD_BIT    (MD_BIT),
    .RB_BIT    (RB_BIT),
    .FD_BIT    (FD_BIT),
    .IMASK_LSB (IMASK_LSB),
    .IMASK_W   (IMASK_W),
    .RST_VEC   (RST_VEC),
    .VEC_TLB   (VEC_TLB),
    .VEC_INT   (VEC_INT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_req    (rst_req),
    .exc_req    (exc_req),
    .exc_code   (exc_code),
    .vec_sel    (vec_sel),
    .int_req    (int_req),
    .imask_mode (imask_mode),
    .rte        (rte),
    .cur_pc     (cur_pc),
    .cur_sr     (cur_sr),
    .cur_r15    (cur_r15),
    .vbr        (vbr),
    .spc        (spc),
    .ssr        (ssr),
    .sgr        (sgr),
    .expevt     (expevt),
    .intevt     (intevt),
    .sr_out     (sr_out),
    .next_pc    (next_pc),
    .br_valid   (br_valid),
    .dbl_err    (dbl_err)
);

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
    localparam int BL = 28, MD = 30, RB = 29, FD = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req = 0, exc_req = 0, int_req = 0, rte = 0, imask_mode = 0;
    logic [11:0] exc_code = 0, int_code = 0;
    logic [1:0]  vec_sel = 0;
    logic [3:0]  int_level = 0;
    logic [31:0] cur_pc = 0, cur_sr = 0, cur_r15 = 0, vbr = 0;
    logic [31:0] spc, ssr, sgr, expevt, intevt, sr_out, next_pc;
    logic        br_valid, dbl_err;

    int n_chk = 0, n_bad = 0, ev_n = 0;
    bit done = 0;

    logic [31:0] m_spc = 0, m_ssr = 0, m_sgr = 0, m_exp = 0, m_int = 0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .exc_req(exc_req),
        .exc_code(exc_code), .vec_sel(vec_sel), .int_req(int_req),
        .int_code(int_code), .int_level(int_level), .imask_mode(imask_mode),
        .rte(rte), .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_r15(cur_r15),
        .vbr(vbr), .spc(spc), .ssr(ssr), .sgr(sgr), .expevt(expevt),
        .intevt(intevt), .sr_out(sr_out), .next_pc(next_pc),
        .br_valid(br_valid), .dbl_err(dbl_err)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exc_offset(input logic [1:0] s);
        return (s == 2'd1) ? 32'h400 : (s == 2'd2) ? 32'h600 : 32'h100;
    endfunction

    // kinds: 0 none, 1 reset, 2 exception, 3 interrupt, 4 return, 5 nested error
    task automatic run_ev(input string pfx, input logic r, input logic e, input logic i,
                          input logic t, input logic [1:0] sel, input logic [3:0] lvl,
                          input logic mode, input logic bl, input logic fd);
        logic [31:0] pc, sr, r15, vb, esr, epc;
        int kind;
        ev_n++;
        pc  = 32'h1000_0000 + ev_n * 4;
        r15 = 32'h8800_0000 ^ (ev_n * 32'h0001_0011);
        vb  = 32'h9C08_0000 + (ev_n << 12);
        sr  = 32'h0000_0003 ^ (ev_n * 32'h2101_0350);
        sr  = (sr & ~((32'h1 << BL) | (32'h1 << FD))) | (32'(bl) << BL) | (32'(fd) << FD);
        if (r)      kind = 1;
        else if (e) kind = bl ? 5 : 2;
        else if (i) kind = bl ? 5 : 3;
        else if (t) kind = 4;
        else        kind = 0;
        esr = sr | (32'h1 << BL) | (32'h1 << MD) | (32'h1 << RB);
        if (kind == 1) esr[FD] = 1'b0;
        if (kind == 3 && mode) esr[7:4] = lvl;
        if (kind == 4) esr = m_ssr;
        case (kind)
            1:       epc = 32'hA000_0000;
            2:       epc = vb + exc_offset(sel);
            3:       epc = vb + 32'h600;
            4:       epc = m_spc;
            default: epc = 32'h0;
        endcase
        @(negedge clk);
        rst_req = r; exc_req = e; int_req = i; rte = t;
        vec_sel = sel; int_level = lvl; imask_mode = mode;
        exc_code = 12'(12'h0A0 + ev_n); int_code = 12'(12'h5C0 + ev_n * 3);
        cur_pc = pc; cur_sr = sr; cur_r15 = r15; vbr = vb;
        @(negedge clk);
        if (kind >= 1 && kind <= 3) begin
            m_spc = pc; m_ssr = sr; m_sgr = r15;
            if (kind == 3) m_int = {20'h0, int_code};
            else           m_exp = {20'h0, exc_code};
        end
        rst_req = 0; exc_req = 0; int_req = 0; rte = 0;
        chk({pfx, " R1/R8/R10 spc"}, spc, m_spc);
        chk({pfx, " R1/R8/R10 ssr"}, ssr, m_ssr);
        chk({pfx, " R1/R8/R10 sgr"}, sgr, m_sgr);
        chk({pfx, " R4 expevt"}, expevt, m_exp);
        chk({pfx, " R4 intevt"}, intevt, m_int);
        chk({pfx, " R11 br_valid"}, 32'(br_valid), 32'(kind >= 1 && kind <= 4));
        chk({pfx, " R10 dbl_err"}, 32'(dbl_err), 32'(kind == 5));
        if (kind >= 1 && kind <= 4) begin
            chk({pfx, " R6/R7/R8 next_pc"}, next_pc, epc);
            if (kind != 4) begin
                chk({pfx, " R2 bl"}, 32'(sr_out[BL]), 32'h1);
                chk({pfx, " R2 md"}, 32'(sr_out[MD]), 32'h1);
                chk({pfx, " R2 rb"}, 32'(sr_out[RB]), 32'h1);
                chk({pfx, " R3 fd"}, 32'(sr_out[FD]), 32'(esr[FD]));
                chk({pfx, " R5 imask"}, 32'(sr_out[7:4]), 32'(esr[7:4]));
            end
            chk({pfx, " R2/R8 sr_out"}, sr_out, esr);
        end
        @(negedge clk);
        chk({pfx, " R11 br_valid idle"}, 32'(br_valid), 32'h0);
        chk({pfx, " R10 dbl_err idle"}, 32'(dbl_err), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 spc", spc, 0);      chk("R12 ssr", ssr, 0);
        chk("R12 sgr", sgr, 0);      chk("R12 expevt", expevt, 0);
        chk("R12 intevt", intevt, 0); chk("R12 sr_out", sr_out, 0);
        chk("R12 next_pc", next_pc, 0);
        chk("R12 pulses", 32'({br_valid, dbl_err}), 0);
        rst_n = 1'b1;
        // R6 / R3: reset entry under every block/FPU-disable state
        for (int b = 0; b < 2; b++)
            for (int f = 0; f < 2; f++)
                run_ev("reset R6", 1, 0, 0, 0, 2'd0, 4'd0, 1'b0, b[0], f[0]);
        // R7: every vector select, both block states, then return R8
        for (int s = 0; s < 4; s++)
            for (int b = 0; b < 2; b++)
                for (int f = 0; f < 2; f++) begin
                    run_ev("exc R7", 0, 1, 0, 0, s[1:0], 4'd0, 1'b0, b[0], f[0]);
                    run_ev("rte R8", 0, 0, 0, 1, 2'd0, 4'd0, 1'b0, 1'b1, f[0]);
                end
        // R5: every level in both mask modes
        for (int m = 0; m < 2; m++)
            for (int l = 0; l < 16; l++)
                for (int b = 0; b < 2; b++)
                    run_ev("int R5", 0, 0, 1, 0, 2'd3, l[3:0], m[0], b[0], l[0]);
        // R9: every strobe combination
        for (int c = 1; c < 16; c++)
            for (int b = 0; b < 2; b++)
                run_ev("prio R9", c[3], c[2], c[1], c[0], 2'd1, 4'd9, 1'b1, b[0], c[1]);
        // R8: two returns in a row restore the same saved state
        run_ev("exc R7", 0, 1, 0, 0, 2'd2, 4'd0, 1'b0, 1'b0, 1'b1);
        run_ev("rte R8", 0, 0, 0, 1, 2'd0, 4'd0, 1'b0, 1'b0, 1'b0);
        run_ev("rte R8", 0, 0, 0, 1, 2'd0, 4'd0, 1'b0, 1'b1, 1'b1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R11 got=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule